// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing front end of an 8192 x 8 byte memory that sits behind a two-wire (I2C) serial bus. It watches the filtered clock and data lines and finds start and stop conditions. It answers only when the first byte carries the fixed device-type code and the three strap bits set on its select inputs. It then takes a two-byte location pointer and moves bytes between the bus and a synchronous memory port, one byte or a whole run at a time.

Writes finish inside the bus transfer. The memory port is strobed during the data byte, so there is never a busy period and the next transaction is acknowledged at once. A single write-protect input blocks every store to the array. The bus side is fully acknowledged even when writes are blocked, so the master cannot tell the difference from the protocol alone. The memory itself lives outside the block on a simple port: address, write strobe, write data, read strobe, and read data returned one clock after the read strobe.

Top module: `i2cmem_slave`

## Requirements
- R1: While reset is held and after it is released with the bus idle, `sdaOe` is 0 and neither `memWe` nor `memRe` is asserted.
- R2: A high-to-low SDA transition while SCL is high (start) begins reception of a slave address. A low-to-high SDA transition while SCL is high (stop) returns the block to idle with SDA released. Either one, arriving in the middle of a byte, discards that byte without any memory write.
- R3: The first byte after a start is matched as bits [7:4] = 4'b1010 and bits [3:1] = `devSel`. On a match the block pulls SDA low (`sdaOe` = 1) for the ninth clock. On a mismatch it leaves SDA released and ignores all traffic until the next start or stop. Bit 0 = 1 selects a read and bit 0 = 0 selects a write.
- R4: In a write transaction, the two bytes after the address are the high and then the low byte of the location pointer. Each is acknowledged. The pointer becomes {high[4:0], low}, and high[7:5] have no effect.
- R5: Each further byte of a write transaction is acknowledged, is stored at the pointer, and advances the pointer by one. The pointer wraps from 8191 to 0.
- R6: While `wpIn` is 1, data bytes are still acknowledged and the pointer still advances, but `memWe` is never asserted and the array keeps its contents.
- R7: A read transaction returns the byte at the current pointer, most significant bit first, and advances the pointer. Each master ACK (SDA low on the ninth clock) fetches and sends the next byte, wrapping from 8191 to 0. A pointer loaded by a write transaction followed by a repeated start is used by the read.
- R8: A master NACK (SDA high on the ninth clock) after a read byte ends the transfer. The block keeps SDA released for all following clocks until a start or stop.
- R9: Incoming bits are taken on rising SCL. `sdaOe` changes only while SCL is low, or under reset.
- R10: A transaction that starts right after the stop that ends a write is acknowledged and served with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are oversampled with it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Filtered bus clock level |
| sdaIn | input | 1 | Filtered bus data level (wired bus value) |
| devSel | input | 3 | Strap value compared with address bits [3:1] |
| wpIn | input | 1 | 1 blocks all stores to the array |
| sdaOe | output | 1 | 1 pulls the open-drain data line low |
| memAddr | output | 13 | Memory location for the current access |
| memWe | output | 1 | One-cycle write strobe |
| memWdata | output | 8 | Byte to store |
| memRe | output | 1 | One-cycle read strobe |
| memRdata | input | 8 | Byte returned one clock after `memRe` |

## Verification
The checker watches several rules on every cycle. It confirms that a store never follows a cycle in which write protect was high, and that the data-line enable never moves while the clock is high. It also checks that a stop always leaves the line released, and that read and write strobes are single, exclusive pulses. Address matching, pointer loading and wrap, byte order on reads, master NACK handling and mid-byte aborts are shown only by the bench. It does this by running whole transactions and comparing acknowledge bits and returned bytes against expected values.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  // Events seen on the oversampled bus lines
  typedef struct packed {
    logic sdaBit;
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
  } busEv_t;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic loadHi;
    logic loadLo;
    logic memWrite;
    logic memRead;
    logic txShift;
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_IGNORE
  } ctrlState_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } byteKind_t;

endpackage

// File: rtl/i2cmem_busdet.sv
module i2cmem_busdet
  import i2cmem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output logic   sclLevel,
  output busEv_t ev
);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclQ;
  logic sdaQ;
  logic sclNow;
  logic sdaNow;

  // idle bus is high, so reset to 1 to avoid false edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclSync[i] <= sclSync[i-1];
        sdaSync[i] <= sdaSync[i-1];
      end
      sclQ <= sclNow;
      sdaQ <= sdaNow;
    end
  end

  assign sclNow   = sclSync[SYNC_STAGES-1];
  assign sdaNow   = sdaSync[SYNC_STAGES-1];
  assign sclLevel = sclNow;

  always_comb begin
    ev.sdaBit  = sdaNow;
    ev.sclRise = sclNow & ~sclQ;
    ev.sclFall = ~sclNow & sclQ;
    ev.startEv = sclNow & sclQ & sdaQ & ~sdaNow;
    ev.stopEv  = sclNow & sclQ & ~sdaQ & sdaNow;
  end

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic      clk,
  input  logic      rstN,
  input  busEv_t    ev,
  input  logic [2:0] devSel,
  input  logic [7:0] rxNext,
  input  logic      txMsb,
  input  logic      txNext,
  output ctrlStrb_t strb,
  output logic      sdaOe
);

  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] BYTE_END = 4'd8;

  ctrlState_t state;
  byteKind_t  kind;
  logic [3:0] bitCnt;
  logic       readDir;
  logic       mAck;
  logic       devMatch;
  logic       noCond;
  logic       lastRise;

  assign devMatch = (rxNext[7:4] == DEV_CODE) && (rxNext[3:1] == devSel);
  assign noCond   = ~ev.startEv & ~ev.stopEv;
  assign lastRise = ev.sclRise && (bitCnt == LAST_BIT);

  always_comb begin
    strb = '0;
    if (noCond) begin
      unique case (state)
        ST_RECV: begin
          if (ev.sclRise && bitCnt < BYTE_END) begin
            strb.rxShift = 1'b1;
            if (lastRise) begin
              unique case (kind)
                BK_DEV:  strb.memRead  = devMatch & rxNext[0];
                BK_AHI:  strb.loadHi   = 1'b1;
                BK_ALO:  strb.loadLo   = 1'b1;
                BK_DATA: strb.memWrite = 1'b1;
                default: ;
              endcase
            end
          end
        end
        ST_SEND: strb.txShift = ev.sclFall && (bitCnt != BYTE_END);
        ST_MACK: strb.memRead = ev.sclRise & ~ev.sdaBit;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= BK_DEV;
      bitCnt  <= '0;
      readDir <= 1'b0;
      mAck    <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (ev.startEv) begin
      state   <= ST_RECV;
      kind    <= BK_DEV;
      bitCnt  <= '0;
      readDir <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (ev.stopEv) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (ev.sclRise && bitCnt < BYTE_END) begin
            bitCnt <= 4'(bitCnt + 1);
            if (lastRise && kind == BK_DEV) begin
              if (devMatch) readDir <= rxNext[0];
              else          state   <= ST_IGNORE;
            end
          end else if (ev.sclFall && bitCnt == BYTE_END) begin
            state <= ST_ACK;
            sdaOe <= 1'b1;
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            bitCnt <= '0;
            if (readDir) begin
              state <= ST_SEND;
              sdaOe <= ~txMsb;
            end else begin
              state <= ST_RECV;
              sdaOe <= 1'b0;
              unique case (kind)
                BK_DEV:  kind <= BK_AHI;
                BK_AHI:  kind <= BK_ALO;
                default: kind <= BK_DATA;
              endcase
            end
          end
        end
        ST_SEND: begin
          if (ev.sclRise) begin
            bitCnt <= 4'(bitCnt + 1);
          end else if (ev.sclFall) begin
            if (bitCnt == BYTE_END) begin
              state <= ST_MACK;
              sdaOe <= 1'b0;
            end else begin
              sdaOe <= ~txNext;
            end
          end
        end
        ST_MACK: begin
          if (ev.sclRise) begin
            mAck <= ~ev.sdaBit;
          end else if (ev.sclFall) begin
            if (mAck) begin
              state  <= ST_SEND;
              bitCnt <= '0;
              sdaOe  <= ~txMsb;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2cmem_datapath.sv
module i2cmem_datapath
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaBit,
  input  logic              wpIn,
  input  ctrlStrb_t         strb,
  input  logic [7:0]        memRdata,
  output logic [7:0]        rxNext,
  output logic              txMsb,
  output logic              txNext,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              memRe
);

  localparam int HI_W = ADDR_W - 8;

  logic [6:0]        rxShift;
  logic [7:0]        txShift;
  logic [HI_W-1:0]   addrHi;
  logic [ADDR_W-1:0] ptr;
  logic              rdValid;

  assign rxNext = {rxShift, sdaBit};
  assign txMsb  = txShift[7];
  assign txNext = txShift[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      addrHi   <= '0;
      ptr      <= '0;
      rdValid  <= 1'b0;
      memAddr  <= '0;
      memWe    <= 1'b0;
      memWdata <= '0;
      memRe    <= 1'b0;
    end else begin
      memWe   <= 1'b0;
      memRe   <= 1'b0;
      rdValid <= memRe;
      if (strb.rxShift) rxShift <= rxNext[6:0];
      if (strb.loadHi)  addrHi  <= rxNext[HI_W-1:0];
      if (strb.loadLo)  ptr     <= {addrHi, rxNext};
      if (strb.memWrite) begin
        memWe    <= ~wpIn;
        memAddr  <= ptr;
        memWdata <= rxNext;
        ptr      <= ptr + 1'b1;
      end
      if (strb.memRead) begin
        memRe   <= 1'b1;
        memAddr <= ptr;
        ptr     <= ptr + 1'b1;
      end
      if (rdValid)           txShift <= memRdata;
      else if (strb.txShift) txShift <= {txShift[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
  import i2cmem_pkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devSel,
  input  logic              wpIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              memRe,
  input  logic [7:0]        memRdata
);

  busEv_t    busEv;
  ctrlStrb_t strb;
  logic      sclLevel;
  logic      stopSeen;
  logic [7:0] rxNext;
  logic      txMsb;
  logic      txNext;

  assign stopSeen = busEv.stopEv;

  i2cmem_busdet #(.SYNC_STAGES(SYNC_STAGES)) u_busdet (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .ev(busEv)
  );

  i2cmem_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(busEv), .devSel(devSel),
    .rxNext(rxNext), .txMsb(txMsb), .txNext(txNext),
    .strb(strb), .sdaOe(sdaOe)
  );

  i2cmem_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaBit(busEv.sdaBit), .wpIn(wpIn),
    .strb(strb), .memRdata(memRdata), .rxNext(rxNext),
    .txMsb(txMsb), .txNext(txNext), .memAddr(memAddr),
    .memWe(memWe), .memWdata(memWdata), .memRe(memRe)
  );

endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk (
  input logic clk,
  input logic rstN,
  input logic wpIn,
  input logic sdaOe,
  input logic memWe,
  input logic memRe,
  input logic sclLevel,
  input logic stopSeen
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!sdaOe && !memWe && !memRe)
        else $error("reset_quiet_chk");
    end
  end

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !$past(wpIn));

  // R9
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !$past(sclLevel));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  // R5
  single_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R5
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R7
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe);

endmodule

bind i2cmem_slave i2cmem_chk u_chk (
  .clk(clk), .rstN(rstN), .wpIn(wpIn), .sdaOe(sdaOe),
  .memWe(memWe), .memRe(memRe), .sclLevel(sclLevel), .stopSeen(stopSeen)
);

// File: tb/i2cmem_slave_tb.sv
module i2cmem_slave_tb;

  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic [2:0] devSel = 3'b101;
  logic sdaOe, memWe, memRe;
  logic [12:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = 8'h00;
  logic sdaBus;

  assign sdaBus = sdaM & ~sdaOe;

  always #10 clk = ~clk;

  i2cmem_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .devSel(devSel),
    .wpIn(wp), .sdaOe(sdaOe), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRe(memRe), .memRdata(memRdata)
  );

  // memory model behind the port
  logic [7:0] memModel [int];
  int weCount = 0;
  always @(posedge clk) begin
    if (memRe) memRdata <= memModel.exists(int'(memAddr)) ? memModel[int'(memAddr)] : 8'h00;
    if (memWe) begin
      memModel[int'(memAddr)] = memWdata;
      weCount++;
    end
  end

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // R9 monitor: enable must not move while the master holds SCL high
  int highMoves = 0;
  logic sdaOePrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && (sdaOe !== sdaOePrev) && sclM) highMoves++;
    sdaOePrev <= sdaOe;
  end

  // scoreboard
  typedef struct { int val; string tag; } item_t;
  item_t expQ[$];
  int obsQ[$];

  task automatic expect_item(int v, string tag);
    item_t it;
    it.val = v;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        if (expQ.size() == 0) begin
          check(obsQ.pop_front(), -1, "unexpected bus result");
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(obsQ.pop_front(), it.val, it.tag);
        end
      end
    end
  end

  // bus master primitives
  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic writeBit(bit b);
    sdaM = b; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0;
  endtask

  task automatic readBit(output bit b);
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H/2);
    b = sdaBus; waitClk(H - H/2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] v);
    bit a;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(a);
    obsQ.push_back(int'(a));
  endtask

  task automatic recvByte(bit ackIt);
    bit b;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    obsQ.push_back(int'(v));
    writeBit(!ackIt);
  endtask

  // start, address and pointer of a write transaction
  task automatic setPtr(logic [7:0] hi, logic [7:0] lo, string tag);
    startCond();
    expect_item(0, {tag, " R3 address ack"}); sendByte(8'hAA);
    expect_item(0, {tag, " R4 high ack"});    sendByte(hi);
    expect_item(0, {tag, " R4 low ack"});     sendByte(lo);
  endtask

  task automatic readStart(string tag);
    startCond();
    expect_item(0, {tag, " R7 read address ack"}); sendByte(8'hAB);
  endtask

  task automatic drain();
    waitClk(4);
    check(expQ.size(), 0, "scoreboard drained");
  endtask

  initial begin
    int weBefore;
    bit b;
    waitClk(4);
    check(int'(sdaOe), 0, "R1 sdaOe in reset");
    check(int'(memWe | memRe), 0, "R1 strobes in reset");
    rstN = 1'b1;
    waitClk(10);
    check(int'({sdaOe, memWe, memRe}), 0, "R1 idle after reset");

    // R4 R5: top pointer bits ignored, sequential write
    setPtr(8'hE1, 8'hFE, "wr");
    expect_item(0, "R5 data ack 0"); sendByte(8'h11);
    expect_item(0, "R5 data ack 1"); sendByte(8'h22);
    expect_item(0, "R5 data ack 2"); sendByte(8'h33);
    stopCond();
    check(int'(memModel.exists(32'h200) ? memModel[32'h200] : 0), 8'h33, "R5 stored at 0x200");

    // R10 R7: immediate new transaction, random then sequential read
    setPtr(8'h01, 8'hFE, "rd");
    readStart("rd");
    expect_item(8'h11, "R7 read byte 0"); recvByte(1'b1);
    expect_item(8'h22, "R7 read byte 1"); recvByte(1'b1);
    expect_item(8'h33, "R10 read after write"); recvByte(1'b0);
    // R8: after NACK the line stays released
    for (int i = 0; i < 3; i++) begin
      readBit(b);
      expect_item(1, "R8 released after nack");
      obsQ.push_back(int'(b));
    end
    stopCond();
    drain();

    // R3: wrong strap bits and wrong type code get no ack
    startCond();
    expect_item(1, "R3 strap mismatch nack"); sendByte(8'hA2);
    expect_item(1, "R3 ignored after mismatch"); sendByte(8'h00);
    stopCond();
    startCond();
    expect_item(1, "R3 type code mismatch nack"); sendByte(8'hBA);
    stopCond();
    drain();

    // R5 R7: pointer wrap on write and read
    setPtr(8'h1F, 8'hFF, "wrap");
    expect_item(0, "R5 wrap ack a"); sendByte(8'h5A);
    expect_item(0, "R5 wrap ack b"); sendByte(8'hA5);
    stopCond();
    check(int'(memModel.exists(0) ? memModel[0] : 0), 8'hA5, "R5 wrapped to 0");
    setPtr(8'h1F, 8'hFF, "wraprd");
    readStart("wraprd");
    expect_item(8'h5A, "R7 read at 8191"); recvByte(1'b1);
    expect_item(8'hA5, "R7 read wrapped 0"); recvByte(1'b0);
    stopCond();
    drain();

    // R6: write protect
    setPtr(8'h00, 8'h10, "wp0");
    expect_item(0, "R6 unprotected ack"); sendByte(8'h3C);
    stopCond();
    wp = 1'b1;
    weBefore = weCount;
    setPtr(8'h00, 8'h10, "wp1");
    expect_item(0, "R6 protected ack 0"); sendByte(8'h77);
    expect_item(0, "R6 protected ack 1"); sendByte(8'h78);
    stopCond();
    check(weCount - weBefore, 0, "R6 no store while protected");
    wp = 1'b0;
    setPtr(8'h00, 8'h10, "wprd");
    readStart("wprd");
    expect_item(8'h3C, "R6 contents kept"); recvByte(1'b0);
    stopCond();
    drain();

    // R2: stop and start in the middle of a byte
    setPtr(8'h00, 8'h40, "ab0");
    expect_item(0, "R2 preload ack"); sendByte(8'h99);
    stopCond();
    weBefore = weCount;
    setPtr(8'h00, 8'h40, "ab1");
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1);
    stopCond();
    check(weCount - weBefore, 0, "R2 stop mid byte no store");
    setPtr(8'h00, 8'h40, "ab2");
    writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    readStart("ab2");
    expect_item(8'h99, "R2 start mid byte keeps data"); recvByte(1'b0);
    stopCond();
    drain();
    check(weCount - weBefore, 0, "R2 start mid byte no store");

    check(highMoves, 0, "R9 sdaOe moved while SCL high");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule